// File: doc/BRIEF.md
# Single-Channel Byte DMA Controller

This block is one byte-wide DMA channel for a microcontroller-style system. Software loads a source pointer, a destination pointer, a byte count and a control byte through a small byte-wide register port. Each byte is moved in two bus cycles. The first cycle reads the byte into a holding register. The second cycle writes it out. Each pointer can address one of three spaces: a 16-bit external RAM space, an 8-bit special-function register space, or an 8-bit internal RAM space. Each pointer either stays fixed or advances by one after every byte.

Two control bits choose how the channel is started and paced. With demand off, setting the enable bit starts the run, and the pacing bit selects one of two behaviours. In alternate-cycle mode the bus is handed back for one cycle after every byte. In burst mode the bus is held until the count is used up. With demand on, each byte waits for a request, either from a serial-port flag or from an external pin. The request is sampled only between bytes. When the count reaches zero, the channel sets a done flag, which drives the interrupt output, and clears its own enable bit. An interrupt acknowledge clears the done flag, and software may also set or clear it.

Top module: `dma_chan`

## Requirements
- R1: After reset all pointer, count and control registers read 0, and `irq`, `bus_own`, `mem_rd` and `mem_wr` are low.
- R2: Register offsets on `cfg_sel`: 0/1 source address low/high byte, 2/3 destination address low/high byte, 4/5 count low/high byte, 6 control byte. The control byte has enable in bit 0, done in bit 1, pacing in bit 2, demand in bit 3, source increment in bit 4, source space in bit 5, destination increment in bit 6 and destination space in bit 7. Every register reads back on `cfg_rdata` in the same cycle.
- R3: Each byte is one cycle with `mem_rd` high at the source address, followed directly by one cycle with `mem_wr` high at the destination address. `mem_wdata` carries the byte that was read.
- R4: The source space comes from its space bit and increment bit. Space 0 selects external RAM, with the increment bit deciding whether the pointer advances. Space 1 with increment 0 selects the SFR space and does not advance. Space 1 with increment 1 selects internal RAM and advances. `mem_space` codes are 0 for external RAM, 1 for SFR and 2 for internal RAM.
- R5: The destination pointer uses the same space and increment decoding as the source pointer.
- R6: An advancing pointer register grows by one after each byte, and a fixed pointer register keeps its value. In the two 8-bit spaces `mem_addr` carries the low 8 bits of the pointer, zero-extended.
- R7: Software alternate-cycle mode (demand 0, pacing 0): after every byte `bus_own` drops for exactly one cycle before the next byte.
- R8: Burst mode (demand 0, pacing 1): `bus_own` stays high from the first read to the last write.
- R9: Serial-flag demand mode (demand 1, pacing 0): a byte starts only when `sp_flag` is high while the channel is between bytes. `ext_req` has no effect in this mode.
- R10: External demand mode (demand 1, pacing 1): a byte starts only when `ext_req` is high between bytes. `sp_flag` has no effect in this mode.
- R11: The count drops by one after each byte. When the last byte completes, done is set and enable is cleared in the next cycle. If enable is set with a zero count, done is set and no bus cycle occurs.
- R12: With enable at 0, no bus cycle occurs, whatever the request inputs do.
- R13: `irq` follows the done bit. A one-cycle pulse on `irq_ack` clears done. A control-byte write sets or clears done directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register offset |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for the offset on `cfg_sel` |
| ext_req | input | 1 | External demand request |
| sp_flag | input | 1 | Serial-port demand flag |
| irq_ack | input | 1 | Interrupt acknowledge, clears done |
| irq | output | 1 | Completion interrupt (done flag) |
| bus_own | output | 1 | Channel holds the bus; low means the CPU has it |
| mem_rd | output | 1 | Read phase strobe |
| mem_wr | output | 1 | Write phase strobe |
| mem_space | output | 2 | Address space of the current access |
| mem_addr | output | 16 | Address of the current access |
| mem_wdata | output | 8 | Byte being written |
| mem_rdata | input | 8 | Byte returned during the read phase |

## Verification
The hardest case to reach is a request arriving on the wrong trigger input while the channel waits between demand bytes. It has to be shown that only the selected input advances the count, and that it advances by exactly one byte per window. The bench holds the unselected input high for several cycles and reads the count back unchanged. It then pulses the selected input for a single cycle and expects exactly one byte. Random runs over every pairing of source and destination space cover the rest. Some of these runs point both pointers into the same space, so that ordering effects between reads and writes are compared against a byte-by-byte model.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

   typedef enum logic [1:0] {
      SPC_XRAM = 2'd0,
      SPC_SFR  = 2'd1,
      SPC_IRAM = 2'd2
   } space_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2
   } phase_e;

   typedef struct packed {
      logic dst_sp;
      logic dst_inc;
      logic src_sp;
      logic src_inc;
      logic demand;
      logic pace;
      logic done;
      logic go;
   } ctrl_t;

   localparam logic [2:0] OFS_SRC_LO = 3'd0;
   localparam logic [2:0] OFS_SRC_HI = 3'd1;
   localparam logic [2:0] OFS_DST_LO = 3'd2;
   localparam logic [2:0] OFS_DST_HI = 3'd3;
   localparam logic [2:0] OFS_CNT_LO = 3'd4;
   localparam logic [2:0] OFS_CNT_HI = 3'd5;
   localparam logic [2:0] OFS_CTRL   = 3'd6;

   function automatic space_e pick_space(input logic sp, input logic inc);
      if (!sp)     return SPC_XRAM;
      else if (inc) return SPC_IRAM;
      else          return SPC_SFR;
   endfunction

   function automatic logic pick_advance(input logic sp, input logic inc);
      return inc;
   endfunction

endpackage

// File: rtl/dma_chan_agen.sv
module dma_chan_agen
   import dma_chan_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int SHORT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_lo,
   input  logic              ld_hi,
   input  logic [7:0]        wdata,
   input  logic              step,
   input  logic              sp_bit,
   input  logic              inc_bit,
   output logic [ADDR_W-1:0] ptr_q,
   output logic [ADDR_W-1:0] bus_addr,
   output space_e            space
);
   localparam int HI_W = ADDR_W - 8;

   logic advance;
   assign space   = pick_space(sp_bit, inc_bit);
   assign advance = pick_advance(sp_bit, inc_bit);

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (ld_lo)
         ptr_q[7:0] <= wdata;
      else if (ld_hi)
         ptr_q[ADDR_W-1:8] <= wdata[HI_W-1:0];
      else if (step && advance)
         ptr_q <= ptr_q + ADDR_W'(1);
   end

   generate
      if (SHORT_W < ADDR_W) begin : g_narrow
         always_comb begin
            if (space == SPC_XRAM) bus_addr = ptr_q;
            else                   bus_addr = {{(ADDR_W-SHORT_W){1'b0}}, ptr_q[SHORT_W-1:0]};
         end
      end else begin : g_flat
         assign bus_addr = ptr_q;
      end
   endgenerate

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && advance && !ld_lo && !ld_hi) |=> ptr_q == ADDR_W'($past(ptr_q) + ADDR_W'(1))); // R6
   AST_PTR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !inc_bit && !ld_lo && !ld_hi) |=> $stable(ptr_q)); // R6
   AST_SFR_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_bit && !inc_bit) |-> space == SPC_SFR); // R4

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_chan_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [2:0]       sel,
   input  logic [7:0]       wdata,
   input  logic             cnt_dec,
   input  logic             fin,
   input  logic             irq_ack,
   output ctrl_t            ctrl,
   output logic [CNT_W-1:0] count
);
   localparam int CHI_W = CNT_W - 8;

   ctrl_t ctrl_n;

   always_comb begin
      ctrl_n = ctrl;
      if (we && sel == OFS_CTRL) ctrl_n = ctrl_t'(wdata);
      else if (irq_ack)          ctrl_n.done = 1'b0;
      if (fin) begin
         ctrl_n.done = 1'b1;
         ctrl_n.go   = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ctrl <= '0;
      else        ctrl <= ctrl_n;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         count <= '0;
      else if (we && sel == OFS_CNT_LO)
         count[7:0] <= wdata;
      else if (we && sel == OFS_CNT_HI)
         count[CNT_W-1:8] <= wdata[CHI_W-1:0];
      else if (cnt_dec)
         count <= count - CNT_W'(1);
   end

   AST_CNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_dec && !we) |=> count == CNT_W'($past(count) - CNT_W'(1))); // R11
   AST_FIN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> (ctrl.done && !ctrl.go)); // R11
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !fin && !we) |=> !ctrl.done); // R13

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
   import dma_chan_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic       demand,
   input  logic       pace,
   input  logic       ext_req,
   input  logic       sp_flag,
   input  logic       cnt_zero,
   input  logic       cnt_one,
   input  logic [7:0] rdata,
   output phase_e     phase,
   output logic [7:0] hold,
   output logic       cnt_dec,
   output logic       step,
   output logic       fin
);
   phase_e phase_n;
   logic   trig;

   assign trig = !demand || (pace ? ext_req : sp_flag);

   always_comb begin
      phase_n = phase;
      cnt_dec = 1'b0;
      step    = 1'b0;
      fin     = 1'b0;
      unique case (phase)
         ST_IDLE: begin
            if (go) begin
               if (cnt_zero)  fin = 1'b1;
               else if (trig) phase_n = ST_RD;
            end
         end
         ST_RD: phase_n = ST_WR;
         ST_WR: begin
            cnt_dec = 1'b1;
            step    = 1'b1;
            if (cnt_one) begin
               fin     = 1'b1;
               phase_n = ST_IDLE;
            end else if (!demand && pace) begin
               phase_n = ST_RD;
            end else begin
               phase_n = ST_IDLE;
            end
         end
         default: phase_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) phase <= ST_IDLE;
      else        phase <= phase_n;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)              hold <= '0;
      else if (phase == ST_RD) hold <= rdata;
   end

   AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == ST_RD) |=> (phase == ST_WR)); // R3
   AST_NO_GO_NO_RD: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == ST_IDLE && !go) |=> (phase == ST_IDLE)); // R12
   AST_ALT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == ST_WR && !demand && !pace) |=> (phase == ST_IDLE)); // R7
   AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == ST_WR && !demand && pace && !cnt_one) |=> (phase == ST_RD)); // R8
   AST_SP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == ST_IDLE && demand && !pace && !sp_flag) |=> (phase == ST_IDLE)); // R9
   AST_EXT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == ST_IDLE && demand && pace && !ext_req) |=> (phase == ST_IDLE)); // R10
   AST_ZERO_NO_RD: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == ST_IDLE && cnt_zero) |=> (phase == ST_IDLE)); // R11

endmodule

// File: rtl/dma_chan.sv
module dma_chan
   import dma_chan_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int SHORT_W = 8,
   parameter int CNT_W   = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [2:0]  cfg_sel,
   input  logic [7:0]  cfg_wdata,
   output logic [7:0]  cfg_rdata,
   input  logic        ext_req,
   input  logic        sp_flag,
   input  logic        irq_ack,
   output logic        irq,
   output logic        bus_own,
   output logic        mem_rd,
   output logic        mem_wr,
   output logic [1:0]  mem_space,
   output logic [15:0] mem_addr,
   output logic [7:0]  mem_wdata,
   input  logic [7:0]  mem_rdata
);
   localparam int NPTR = 2;
   localparam int IDX_SRC = 0;
   localparam int IDX_DST = 1;

   if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
      $error("dma_chan: ADDR_W must lie in 9..16");
   end
   if (SHORT_W < 1 || SHORT_W > 8) begin : g_bad_short
      $error("dma_chan: SHORT_W must lie in 1..8");
   end
   if (CNT_W < 9 || CNT_W > 16) begin : g_bad_cnt
      $error("dma_chan: CNT_W must lie in 9..16");
   end

   ctrl_t            ctrl;
   logic [CNT_W-1:0] count;
   phase_e           phase;
   logic [7:0]       hold;
   logic             cnt_dec, step, fin;

   logic [ADDR_W-1:0] ptr_q   [NPTR];
   logic [ADDR_W-1:0] ptr_bus [NPTR];
   space_e            ptr_spc [NPTR];
   logic [NPTR-1:0]   sp_bits, inc_bits;

   assign sp_bits  = {ctrl.dst_sp,  ctrl.src_sp};
   assign inc_bits = {ctrl.dst_inc, ctrl.src_inc};

   dma_chan_regs #(.CNT_W(CNT_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .sel     (cfg_sel),
      .wdata   (cfg_wdata),
      .cnt_dec (cnt_dec),
      .fin     (fin),
      .irq_ack (irq_ack),
      .ctrl    (ctrl),
      .count   (count)
   );

   generate
      for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
         localparam logic [2:0] BASE = 3'(2 * gi);
         dma_chan_agen #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_agen (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld_lo    (cfg_we && cfg_sel == BASE),
            .ld_hi    (cfg_we && cfg_sel == BASE + 3'd1),
            .wdata    (cfg_wdata),
            .step     (step),
            .sp_bit   (sp_bits[gi]),
            .inc_bit  (inc_bits[gi]),
            .ptr_q    (ptr_q[gi]),
            .bus_addr (ptr_bus[gi]),
            .space    (ptr_spc[gi])
         );
      end
   endgenerate

   dma_chan_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (ctrl.go),
      .demand   (ctrl.demand),
      .pace     (ctrl.pace),
      .ext_req  (ext_req),
      .sp_flag  (sp_flag),
      .cnt_zero (count == '0),
      .cnt_one  (count == CNT_W'(1)),
      .rdata    (mem_rdata),
      .phase    (phase),
      .hold     (hold),
      .cnt_dec  (cnt_dec),
      .step     (step),
      .fin      (fin)
   );

   logic [15:0] src16, dst16, cnt16;
   assign src16 = 16'(ptr_q[IDX_SRC]);
   assign dst16 = 16'(ptr_q[IDX_DST]);
   assign cnt16 = 16'(count);

   always_comb begin
      unique case (cfg_sel)
         OFS_SRC_LO: cfg_rdata = src16[7:0];
         OFS_SRC_HI: cfg_rdata = src16[15:8];
         OFS_DST_LO: cfg_rdata = dst16[7:0];
         OFS_DST_HI: cfg_rdata = dst16[15:8];
         OFS_CNT_LO: cfg_rdata = cnt16[7:0];
         OFS_CNT_HI: cfg_rdata = cnt16[15:8];
         OFS_CTRL:   cfg_rdata = ctrl;
         default:    cfg_rdata = 8'h00;
      endcase
   end

   assign irq       = ctrl.done;
   assign mem_rd    = (phase == ST_RD);
   assign mem_wr    = (phase == ST_WR);
   assign bus_own   = (phase != ST_IDLE);
   assign mem_wdata = hold;
   assign mem_addr  = 16'(mem_wr ? ptr_bus[IDX_DST] : ptr_bus[IDX_SRC]);
   assign mem_space = mem_wr ? ptr_spc[IDX_DST] : ptr_spc[IDX_SRC];

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd, mem_wr})); // R3
   AST_WDATA_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> (mem_wr && mem_wdata == $past(mem_rdata))); // R3
   AST_IRQ_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && count == CNT_W'(1)) |=> (irq && count == '0)); // R11

endmodule

// File: tb/dma_chan_tb.sv
module dma_chan_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = 3'd0;
   logic [7:0]  cfg_wdata = 8'h00;
   logic [7:0]  cfg_rdata;
   logic        ext_req = 1'b0;
   logic        sp_flag = 1'b0;
   logic        irq_ack = 1'b0;
   logic        irq, bus_own, mem_rd, mem_wr;
   logic [1:0]  mem_space;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata;

   always #10 clk = ~clk;

   dma_chan u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ext_req(ext_req),
      .sp_flag(sp_flag), .irq_ack(irq_ack), .irq(irq), .bus_own(bus_own),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_space(mem_space),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   logic [7:0] xram [65536];
   logic [7:0] sfr  [256];
   logic [7:0] iram [256];
   logic [7:0] sh_x [65536];
   logic [7:0] sh_s [256];
   logic [7:0] sh_i [256];

   always_comb begin
      case (mem_space)
         2'd0:    mem_rdata = xram[mem_addr];
         2'd1:    mem_rdata = sfr[mem_addr[7:0]];
         2'd2:    mem_rdata = iram[mem_addr[7:0]];
         default: mem_rdata = 8'hxx;
      endcase
   end

   always @(posedge clk) begin
      if (mem_wr) begin
         case (mem_space)
            2'd0:    xram[mem_addr] <= mem_wdata;
            2'd1:    sfr[mem_addr[7:0]] <= mem_wdata;
            2'd2:    iram[mem_addr[7:0]] <= mem_wdata;
            default: ;
         endcase
      end
   end

   int n_rd = 0, n_wr = 0, n_rise = 0, n_own = 0;
   int n_badaddr = 0;
   logic own_d = 1'b0;
   logic [1:0]  exp_spc_s = 2'd0, exp_spc_d = 2'd0;
   always @(negedge clk) begin
      if (mem_rd) begin
         n_rd++;
         if (mem_space != exp_spc_s) n_badaddr++;
      end
      if (mem_wr) begin
         n_wr++;
         if (mem_space != exp_spc_d) n_badaddr++;
      end
      if (bus_own) n_own++;
      if (bus_own && !own_d) n_rise++;
      own_d = bus_own;
   end

   int tests = 0, fails = 0;
   int cyc = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
         finish_run();
      end
   end

   task automatic wr(input logic [2:0] s, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] s, output logic [7:0] d);
      cfg_sel = s;
      #1;
      d = cfg_rdata;
   endtask

   function automatic logic [1:0] spc(input logic b, input logic i);
      if (!b) return 2'd0;
      return i ? 2'd2 : 2'd1;
   endfunction

   function automatic logic [7:0] ctrl_byte(input logic db, di, sb, si, dm, tm, dn, go);
      return {db, di, sb, si, dm, tm, dn, go};
   endfunction

   function automatic logic [7:0] sh_rd(input logic [1:0] s, input logic [15:0] a);
      if (s == 2'd0) return sh_x[a];
      if (s == 2'd1) return sh_s[a[7:0]];
      return sh_i[a[7:0]];
   endfunction

   task automatic sh_wr(input logic [1:0] s, input logic [15:0] a, input logic [7:0] v);
      if (s == 2'd0) sh_x[a] = v;
      else if (s == 2'd1) sh_s[a[7:0]] = v;
      else sh_i[a[7:0]] = v;
   endtask

   task automatic model(input logic [1:0] ss, input logic si, input logic [15:0] sa,
                        input logic [1:0] ds, input logic di, input logic [15:0] da, input int n);
      for (int k = 0; k < n; k++) begin
         logic [15:0] a_s, a_d;
         a_s = si ? 16'(sa + 16'(k)) : sa;
         a_d = di ? 16'(da + 16'(k)) : da;
         sh_wr(ds, a_d, sh_rd(ss, a_s));
      end
   endtask

   function automatic int mem_diff();
      int d = 0;
      for (int k = 0; k < 65536; k++) if (xram[k] !== sh_x[k]) d++;
      for (int k = 0; k < 256; k++) begin
         if (sfr[k] !== sh_s[k]) d++;
         if (iram[k] !== sh_i[k]) d++;
      end
      return d;
   endfunction

   task automatic load(input logic [15:0] sa, input logic [15:0] da, input logic [15:0] n);
      wr(3'd0, sa[7:0]); wr(3'd1, sa[15:8]);
      wr(3'd2, da[7:0]); wr(3'd3, da[15:8]);
      wr(3'd4, n[7:0]);  wr(3'd5, n[15:8]);
   endtask

   task automatic wait_irq(output bit ok);
      ok = 1'b0;
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         if (irq) begin ok = 1'b1; break; end
      end
   endtask

   task automatic ack();
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
   endtask

   task automatic run_sw(input logic sb, si, db, di, tm, input logic [15:0] sa, da, input int n);
      int r0, w0, q0, o0, b0, dff;
      bit ok;
      logic [7:0] v, lo, hi;
      logic [15:0] exp_s, exp_d;
      exp_spc_s = spc(sb, si); exp_spc_d = spc(db, di);
      load(sa, da, 16'(n));
      r0 = n_rd; w0 = n_wr; q0 = n_rise; o0 = n_own; b0 = n_badaddr;
      wr(3'd6, ctrl_byte(db, di, sb, si, 1'b0, tm, 1'b0, 1'b1));
      wait_irq(ok);
      chk(ok, "R11 irq after count", int'(ok), 1);
      model(spc(sb, si), si, sa, spc(db, di), di, da, n);
      dff = mem_diff();
      chk(dff == 0, "R3 R4 R5 memory contents", dff, 0);
      chk(n_badaddr == b0, "R4 R5 bus space code", n_badaddr - b0, 0);
      chk(n_rd - r0 == n && n_wr - w0 == n, "R3 read/write count", n_rd - r0, n);
      chk(n_own - o0 == 2 * n, "R3 owned cycles", n_own - o0, 2 * n);
      if (tm) chk(n_rise - q0 == 1, "R8 burst single tenure", n_rise - q0, 1);
      else    chk(n_rise - q0 == n, "R7 alternate tenures", n_rise - q0, n);
      rd(3'd6, v);
      chk(v[1] && !v[0], "R11 done set, go cleared", int'(v), int'(v | 8'h02) & ~1);
      rd(3'd4, lo); rd(3'd5, hi);
      chk({hi, lo} == 16'd0, "R11 count zero", int'({hi, lo}), 0);
      exp_s = si ? 16'(sa + 16'(n)) : sa;
      exp_d = di ? 16'(da + 16'(n)) : da;
      rd(3'd0, lo); rd(3'd1, hi);
      chk({hi, lo} == exp_s, "R6 source pointer", int'({hi, lo}), int'(exp_s));
      rd(3'd2, lo); rd(3'd3, hi);
      chk({hi, lo} == exp_d, "R6 destination pointer", int'({hi, lo}), int'(exp_d));
      ack();
      chk(!irq, "R13 ack clears irq", int'(irq), 0);
   endtask

   task automatic demand_test(input logic tm);
      logic [7:0] lo, v;
      int r0, dff;
      string rq;
      rq = tm ? "R10" : "R9";
      exp_spc_s = 2'd0; exp_spc_d = 2'd2;
      load(16'h1200, 16'h0040, 16'd3);
      r0 = n_rd;
      wr(3'd6, ctrl_byte(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, tm, 1'b0, 1'b1));
      @(negedge clk);
      if (tm) sp_flag = 1'b1; else ext_req = 1'b1;
      repeat (8) @(negedge clk);
      sp_flag = 1'b0; ext_req = 1'b0;
      rd(3'd4, lo);
      chk(lo == 8'd3 && n_rd == r0, {rq, " wrong trigger ignored"}, int'(lo), 3);
      if (tm) ext_req = 1'b1; else sp_flag = 1'b1;
      @(negedge clk);
      ext_req = 1'b0; sp_flag = 1'b0;
      repeat (4) @(negedge clk);
      rd(3'd4, lo);
      chk(lo == 8'd2, {rq, " one byte per request"}, int'(lo), 2);
      if (tm) ext_req = 1'b1; else sp_flag = 1'b1;
      repeat (12) @(negedge clk);
      ext_req = 1'b0; sp_flag = 1'b0;
      rd(3'd6, v);
      chk(irq && !v[0], {rq, " demand run completes"}, int'(irq), 1);
      model(2'd0, 1'b1, 16'h1200, 2'd2, 1'b1, 16'h0040, 3);
      dff = mem_diff();
      chk(dff == 0, {rq, " demand memory"}, dff, 0);
      ack();
   endtask

   initial begin
      logic [7:0] v;
      int r0;
      bit ok;
      void'($urandom(32'd4242));
      for (int k = 0; k < 65536; k++) begin xram[k] = 8'($urandom); sh_x[k] = xram[k]; end
      for (int k = 0; k < 256; k++) begin
         sfr[k] = 8'($urandom); sh_s[k] = sfr[k];
         iram[k] = 8'($urandom); sh_i[k] = iram[k];
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int s = 0; s < 7; s++) begin
         rd(3'(s), v);
         chk(v == 8'h00, "R1 register reset", int'(v), 0);
      end
      chk(!irq && !bus_own && !mem_rd && !mem_wr, "R1 outputs idle",
          int'({irq, bus_own, mem_rd, mem_wr}), 0);

      // R2 readback of each register
      load(16'hA55A, 16'h3CC3, 16'h0000);
      rd(3'd0, v); chk(v == 8'h5A, "R2 src lo", int'(v), 8'h5A);
      rd(3'd1, v); chk(v == 8'hA5, "R2 src hi", int'(v), 8'hA5);
      rd(3'd2, v); chk(v == 8'hC3, "R2 dst lo", int'(v), 8'hC3);
      rd(3'd3, v); chk(v == 8'h3C, "R2 dst hi", int'(v), 8'h3C);
      wr(3'd6, 8'hF4);
      rd(3'd6, v); chk(v == 8'hF4, "R2 control byte", int'(v), 8'hF4);
      wr(3'd6, 8'h00);

      // R12 no transfers without enable
      wr(3'd4, 8'd5);
      wr(3'd6, ctrl_byte(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0));
      r0 = n_rd;
      ext_req = 1'b1; sp_flag = 1'b1;
      repeat (10) @(negedge clk);
      ext_req = 1'b0; sp_flag = 1'b0;
      rd(3'd4, v);
      chk(n_rd == r0 && v == 8'd5, "R12 idle without enable", n_rd - r0, 0);

      // R11 enable with zero count
      wr(3'd4, 8'd0);
      r0 = n_rd;
      wr(3'd6, ctrl_byte(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1));
      wait_irq(ok);
      rd(3'd6, v);
      chk(ok && n_rd == r0 && !v[0], "R11 zero count finishes at once", n_rd - r0, 0);

      // R13 acknowledge and software set/clear
      ack();
      chk(!irq, "R13 ack clears", int'(irq), 0);
      wr(3'd6, 8'h02);
      chk(irq, "R13 software set done", int'(irq), 1);
      wr(3'd6, 8'h00);
      chk(!irq, "R13 software clear done", int'(irq), 0);

      // Directed corners: short-space wrap, fixed pointers, both modes
      run_sw(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'h00FE, 16'h8000, 4); // R6 iram wrap
      run_sw(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0090, 16'h0010, 3); // R4 sfr fixed
      run_sw(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'hFFFE, 16'h00A0, 5); // R5 sfr dest

      // R9 / R10 demand modes
      demand_test(1'b0);
      demand_test(1'b1);

      // Random runs over all space pairings and both software modes
      for (int t = 0; t < 24; t++) begin
         logic sb, si, db, di, tm;
         logic [15:0] sa, da;
         int n;
         sb = 1'($urandom); si = 1'($urandom);
         db = 1'($urandom); di = 1'($urandom);
         tm = 1'($urandom);
         sa = 16'($urandom); da = 16'($urandom);
         n = 1 + int'($urandom % 6);
         run_sw(sb, si, db, di, tm, sa, da, n);
      end

      finish_run();
   end
endmodule